// File: doc/BRIEF.md
# Codec Read Timeout Guard

This block takes a host request to read one codec register and turns it into a one-cycle command strobe toward the serial codec link. While that command is outstanding, it counts codec frames by watching for rising edges of the frame-sync strobe. The read finishes in one of two ways. If the codec's response strobe arrives within the allowed frame window, the returned data goes back to the host. If it does not, the host read is completed anyway with every data bit forced to one, and a sticky status flag records that a read has timed out.

Only one codec read can be in flight. Each host request carries a byte address and a size code. A request whose bytes would run past the end of an aligned 32-bit word is refused at once. No link command is sent for it, and the host sees an error completion.

Top module: `codec_read_guard`

## Requirements
- R1: After reset, `hostReqReady` is 1, `hostRspValid` and `linkCmdValid` are 0, and `rdTimeoutSts` is 0.
- R2: A request accepted in cycle t (`hostReqValid` and `hostReqReady` both high) that does not cross a word boundary raises `linkCmdValid` for exactly cycle t+1. In that cycle `linkCmdAddr` equals the accepted `hostReqAddr`.
- R3: From the cycle after acceptance until a completion is presented, `hostReqReady` is 0. No second link command is issued while a read is pending.
- R4: When `linkRspValid` is high in a cycle while a read is pending, the next cycle shows `hostRspValid`=1 with `hostRspData` equal to the sampled `linkRspData` and `hostRspErr`=0, and `hostReqReady` returns to 1.
- R5: Frames are counted only as 0-to-1 transitions of `frameSync` seen while a read is pending. The count starts from zero at each accepted read. A high level lasting several cycles counts once, and edges seen while idle are not counted.
- R6: If the 4th counted frame edge (parameter MAX_FRAMES) arrives without a response, the next cycle shows `hostRspValid`=1, `hostRspErr`=0 and `hostRspData` with all bits set.
- R7: A timed-out read sets `rdTimeoutSts` in the same cycle that its all-ones completion is presented.
- R8: `rdTimeoutSts` stays 1 until a cycle with `statusClr`=1 clears it on the next cycle. A timeout and a clear in the same cycle leave it at 1.
- R9: Size code `hostReqSize` gives 2^code bytes (0:1, 1:2, 2:4, 3:8). A request with `hostReqAddr[1:0]` + bytes > 4 issues no link command. In the next cycle it completes with `hostRspValid`=1, `hostRspErr`=1 and `hostRspData`=0, and it leaves `rdTimeoutSts` unchanged.
- R10: If a response and the final frame edge fall in the same cycle, the response wins. The codec data is returned and `rdTimeoutSts` is not set by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReqValid | input | 1 | Host read request strobe |
| hostReqReady | output | 1 | High when a new read can be accepted |
| hostReqAddr | input | ADDR_W | Byte address of the codec register |
| hostReqSize | input | 2 | Access size code, bytes = 2^code |
| hostRspValid | output | 1 | One-cycle completion strobe |
| hostRspData | output | DATA_W | Completion data |
| hostRspErr | output | 1 | Completion refused for crossing a word boundary |
| linkCmdValid | output | 1 | One-cycle read command toward the codec link |
| linkCmdAddr | output | ADDR_W | Register address carried by the command |
| frameSync | input | 1 | Link frame-sync strobe, synchronous to clk |
| linkRspValid | input | 1 | Codec response slot received |
| linkRspData | input | DATA_W | Codec response data |
| statusClr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| rdTimeoutSts | output | 1 | Sticky read-timeout status |

## Verification
The assertions assume that `frameSync` is already synchronous to `clk`, so a rising edge is simply a low sample followed by a high one. They also assume that `linkRspValid` has meaning only while a read is pending. The bench keeps to both assumptions. It holds `frameSync` low while idle, or drives it as pulses of one or more high cycles separated by at least one low cycle. It raises the response strobe only inside the wait window of an accepted read. The random pulse widths, frame periods, response cycles and clear cycles are chosen so that responses land before the final edge, on it and after it.

// File: rtl/crg_pkg.sv
package crg_pkg;
  typedef struct packed {
    logic issue;
    logic countEn;
    logic takeData;
    logic takeTimeout;
    logic takeReject;
  } crgStrobes_t;
endpackage

// File: rtl/crg_ctrl.sv
module crg_ctrl
  import crg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReqValid,
  input  logic        crossing,
  input  logic        frameEdge,
  input  logic        lastFrame,
  input  logic        linkRspValid,
  output logic        hostReqReady,
  output crgStrobes_t strobes
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (hostReqValid) begin
          if (crossing) begin
            strobes.takeReject = 1'b1;
          end else begin
            strobes.issue = 1'b1;
            stateNext     = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        strobes.countEn = 1'b1;
        if (linkRspValid) begin
          strobes.takeData = 1'b1;
          stateNext        = ST_IDLE;
        end else if (frameEdge && lastFrame) begin
          strobes.takeTimeout = 1'b1;
          stateNext           = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign hostReqReady = (state == ST_IDLE);
endmodule

// File: rtl/crg_datapath.sv
module crg_datapath
  import crg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int MAX_FRAMES = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  crgStrobes_t       strobes,
  input  logic [ADDR_W-1:0] hostReqAddr,
  input  logic [1:0]        hostReqSize,
  input  logic              frameSync,
  input  logic [DATA_W-1:0] linkRspData,
  input  logic              statusClr,
  output logic              crossing,
  output logic              frameEdge,
  output logic              lastFrame,
  output logic              linkCmdValid,
  output logic [ADDR_W-1:0] linkCmdAddr,
  output logic              hostRspValid,
  output logic [DATA_W-1:0] hostRspData,
  output logic              hostRspErr,
  output logic              rdTimeoutSts
);
  localparam int CNT_W = $clog2(MAX_FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_FRAMES - 1);

  logic [CNT_W-1:0] frameCnt;
  logic             fsPrev;
  logic [3:0]       endByte;

  // bytes of the access, added to the offset inside the 32-bit word
  assign endByte  = {2'b00, hostReqAddr[1:0]} + (4'd1 << hostReqSize);
  assign crossing = (endByte > 4'd4);

  assign frameEdge = frameSync && !fsPrev;
  assign lastFrame = (frameCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsPrev   <= 1'b0;
      frameCnt <= '0;
    end else begin
      fsPrev <= frameSync;
      if (strobes.issue)                      frameCnt <= '0;
      else if (strobes.countEn && frameEdge)  frameCnt <= frameCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkCmdValid <= 1'b0;
      linkCmdAddr  <= '0;
    end else begin
      linkCmdValid <= strobes.issue;
      if (strobes.issue) linkCmdAddr <= hostReqAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRspValid <= 1'b0;
      hostRspData  <= '0;
      hostRspErr   <= 1'b0;
    end else begin
      hostRspValid <= strobes.takeData | strobes.takeTimeout | strobes.takeReject;
      hostRspErr   <= strobes.takeReject;
      if (strobes.takeData)         hostRspData <= linkRspData;
      else if (strobes.takeTimeout) hostRspData <= '1;
      else if (strobes.takeReject)  hostRspData <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    rdTimeoutSts <= 1'b0;
    else if (strobes.takeTimeout) rdTimeoutSts <= 1'b1;
    else if (statusClr)           rdTimeoutSts <= 1'b0;
  end
endmodule

// File: rtl/codec_read_guard.sv
module codec_read_guard
  import crg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int MAX_FRAMES = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReqValid,
  output logic              hostReqReady,
  input  logic [ADDR_W-1:0] hostReqAddr,
  input  logic [1:0]        hostReqSize,
  output logic              hostRspValid,
  output logic [DATA_W-1:0] hostRspData,
  output logic              hostRspErr,
  output logic              linkCmdValid,
  output logic [ADDR_W-1:0] linkCmdAddr,
  input  logic              frameSync,
  input  logic              linkRspValid,
  input  logic [DATA_W-1:0] linkRspData,
  input  logic              statusClr,
  output logic              rdTimeoutSts
);
  crgStrobes_t strobes;
  logic crossing, frameEdge, lastFrame;

  crg_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostReqValid (hostReqValid),
    .crossing     (crossing),
    .frameEdge    (frameEdge),
    .lastFrame    (lastFrame),
    .linkRspValid (linkRspValid),
    .hostReqReady (hostReqReady),
    .strobes      (strobes)
  );

  crg_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MAX_FRAMES (MAX_FRAMES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .hostReqAddr  (hostReqAddr),
    .hostReqSize  (hostReqSize),
    .frameSync    (frameSync),
    .linkRspData  (linkRspData),
    .statusClr    (statusClr),
    .crossing     (crossing),
    .frameEdge    (frameEdge),
    .lastFrame    (lastFrame),
    .linkCmdValid (linkCmdValid),
    .linkCmdAddr  (linkCmdAddr),
    .hostRspValid (hostRspValid),
    .hostRspData  (hostRspData),
    .hostRspErr   (hostRspErr),
    .rdTimeoutSts (rdTimeoutSts)
  );
endmodule

// File: rtl/crg_checker.sv
module crg_checker #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int MAX_FRAMES = 4
)(
  input logic              clk,
  input logic              rstN,
  input logic              hostReqValid,
  input logic              hostReqReady,
  input logic [ADDR_W-1:0] hostReqAddr,
  input logic [1:0]        hostReqSize,
  input logic              hostRspValid,
  input logic [DATA_W-1:0] hostRspData,
  input logic              hostRspErr,
  input logic              linkCmdValid,
  input logic [ADDR_W-1:0] linkCmdAddr,
  input logic              frameSync,
  input logic              linkRspValid,
  input logic [DATA_W-1:0] linkRspData,
  input logic              statusClr,
  input logic              rdTimeoutSts
);
  localparam int CW = $clog2(MAX_FRAMES + 1) + 1;

  logic          chkFsPrev;
  logic [CW-1:0] chkCnt;
  logic          chkCross;

  assign chkCross = (int'(hostReqAddr[1:0]) + (1 << hostReqSize)) > 4;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkFsPrev <= 1'b0;
      chkCnt    <= '0;
    end else begin
      chkFsPrev <= frameSync;
      if (hostReqValid && hostReqReady)                 chkCnt <= '0;
      else if (!hostReqReady && frameSync && !chkFsPrev) chkCnt <= chkCnt + 1'b1;
    end
  end

  AST_CMD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    linkCmdValid |-> (linkCmdAddr == $past(hostReqAddr)) && $past(hostReqValid && hostReqReady)); // R2

  AST_SINGLE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    linkCmdValid |-> !hostReqReady); // R3

  AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !hostReqReady |=> !linkCmdValid); // R3

  AST_DATA_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (!hostReqReady && linkRspValid) |=> hostRspValid && !hostRspErr && (hostRspData == $past(linkRspData))); // R4

  AST_FRAME_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    !hostReqReady |-> (chkCnt < CW'(MAX_FRAMES))); // R5

  AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdTimeoutSts) |-> hostRspValid && !hostRspErr && (&hostRspData)); // R6

  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rdTimeoutSts && !statusClr) |=> rdTimeoutSts); // R8

  AST_REJECT_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (hostReqValid && hostReqReady && chkCross) |=> !linkCmdValid && hostRspValid && hostRspErr && hostRspData == '0); // R9

  AST_RSP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (!hostReqReady && linkRspValid && !statusClr) |=> (rdTimeoutSts == $past(rdTimeoutSts))); // R10
endmodule

bind codec_read_guard crg_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .MAX_FRAMES (MAX_FRAMES)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .hostReqValid (hostReqValid),
  .hostReqReady (hostReqReady),
  .hostReqAddr  (hostReqAddr),
  .hostReqSize  (hostReqSize),
  .hostRspValid (hostRspValid),
  .hostRspData  (hostRspData),
  .hostRspErr   (hostRspErr),
  .linkCmdValid (linkCmdValid),
  .linkCmdAddr  (linkCmdAddr),
  .frameSync    (frameSync),
  .linkRspValid (linkRspValid),
  .linkRspData  (linkRspData),
  .statusClr    (statusClr),
  .rdTimeoutSts (rdTimeoutSts)
);

// File: tb/sim_codec_read_guard.sv
module sim_codec_read_guard;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int MAXF   = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN;
  logic              hostReqValid, hostReqReady;
  logic [ADDR_W-1:0] hostReqAddr;
  logic [1:0]        hostReqSize;
  logic              hostRspValid, hostRspErr;
  logic [DATA_W-1:0] hostRspData;
  logic              linkCmdValid;
  logic [ADDR_W-1:0] linkCmdAddr;
  logic              frameSync, linkRspValid, statusClr, rdTimeoutSts;
  logic [DATA_W-1:0] linkRspData;

  codec_read_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_FRAMES(MAXF)) u0 (
    .clk(clk), .rstN(rstN),
    .hostReqValid(hostReqValid), .hostReqReady(hostReqReady),
    .hostReqAddr(hostReqAddr), .hostReqSize(hostReqSize),
    .hostRspValid(hostRspValid), .hostRspData(hostRspData), .hostRspErr(hostRspErr),
    .linkCmdValid(linkCmdValid), .linkCmdAddr(linkCmdAddr),
    .frameSync(frameSync), .linkRspValid(linkRspValid), .linkRspData(linkRspData),
    .statusClr(statusClr), .rdTimeoutSts(rdTimeoutSts)
  );

  int  nTests = 0;
  int  nFail  = 0;
  bit  expSts = 1'b0;
  int  cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit crossOf(input logic [ADDR_W-1:0] a, input logic [1:0] s);
    return (int'(a[1:0]) + (1 << s)) > 4;
  endfunction

  task automatic idleFrames(input int n);
    for (int i = 0; i < n; i++) begin
      frameSync = 1'b1; @(negedge clk);
      frameSync = 1'b0; @(negedge clk);
    end
  endtask

  task automatic clearSts();
    statusClr = 1'b1; @(negedge clk);
    statusClr = 1'b0;
    expSts = 1'b0;
    chk(rdTimeoutSts == 1'b0, "R8", "flag after clear", 32'(rdTimeoutSts), 32'(expSts));
  endtask

  // frame pattern: frameSync high when (cyc % P) >= P-H
  task automatic runRead(input logic [ADDR_W-1:0] a, input logic [1:0] s,
                         input int P, input int H, input int rspCyc, input int clrCyc);
    int edges;
    bit done, fsPrevB, fsNow, edgeNow, isTo;
    logic [DATA_W-1:0] d, expData;
    chk(hostReqReady == 1'b1, "R3", "ready before request", 32'(hostReqReady), 32'd1);
    frameSync = 1'b0;
    hostReqValid = 1'b1; hostReqAddr = a; hostReqSize = s;
    @(negedge clk);
    hostReqValid = 1'b0;
    if (crossOf(a, s)) begin
      chk(hostRspValid && hostRspErr, "R9", "reject completion", {30'd0, hostRspValid, hostRspErr}, 32'd3);
      chk(hostRspData == '0, "R9", "reject data", 32'(hostRspData), 32'd0);
      chk(!linkCmdValid, "R9", "no link command", 32'(linkCmdValid), 32'd0);
      chk(rdTimeoutSts == expSts, "R9", "flag untouched", 32'(rdTimeoutSts), 32'(expSts));
      return;
    end
    chk(linkCmdValid == 1'b1, "R2", "command strobe", 32'(linkCmdValid), 32'd1);
    chk(linkCmdAddr == a, "R2", "command address", 32'(linkCmdAddr), 32'(a));
    chk(!hostReqReady, "R3", "ready low while pending", 32'(hostReqReady), 32'd0);
    edges = 0; done = 1'b0; fsPrevB = 1'b0; expData = '0;
    for (int cyc = 0; !done && cyc < 64; cyc++) begin
      fsNow   = (cyc % P) >= (P - H);
      edgeNow = fsNow && !fsPrevB;
      d = DATA_W'($urandom);
      frameSync    = fsNow;
      linkRspValid = (cyc == rspCyc);
      linkRspData  = d;
      statusClr    = (cyc == clrCyc);
      @(negedge clk);
      fsPrevB = fsNow;
      if (edgeNow) edges++;
      isTo = 1'b0;
      if (cyc == rspCyc) begin
        expData = d; done = 1'b1;
      end else if (edgeNow && edges == MAXF) begin
        expData = '1; done = 1'b1; isTo = 1'b1;
      end
      if (isTo) expSts = 1'b1;
      else if (cyc == clrCyc) expSts = 1'b0;
      chk(rdTimeoutSts == expSts, "R7/R8", "timeout flag", 32'(rdTimeoutSts), 32'(expSts));
      if (done) begin
        chk(hostRspValid && !hostRspErr, isTo ? "R6" : "R4", "completion strobe",
            {30'd0, hostRspValid, hostRspErr}, 32'd2);
        chk(hostRspData == expData, isTo ? "R6" : "R4 R10", "completion data",
            32'(hostRspData), 32'(expData));
        chk(hostReqReady, "R4", "ready after completion", 32'(hostReqReady), 32'd1);
      end else begin
        chk(!hostRspValid && !hostReqReady, "R5", "still pending", {30'd0, hostRspValid, hostReqReady}, 32'd0);
        chk(!linkCmdValid, "R3", "single command", 32'(linkCmdValid), 32'd0);
      end
    end
    frameSync = 1'b0; linkRspValid = 1'b0; statusClr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; hostReqValid = 1'b0; hostReqAddr = '0; hostReqSize = '0;
    frameSync = 1'b0; linkRspValid = 1'b0; linkRspData = '0; statusClr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(hostReqReady == 1'b1, "R1", "reset ready", 32'(hostReqReady), 32'd1);
    chk(!hostRspValid && !linkCmdValid, "R1", "reset strobes", {30'd0, hostRspValid, linkCmdValid}, 32'd0);
    chk(rdTimeoutSts == 1'b0, "R1", "reset flag", 32'(rdTimeoutSts), 32'd0);

    runRead(8'h10, 2'd2, 3, 1, 2, -1);     // R4 early response
    runRead(8'h20, 2'd1, 3, 1, -1, -1);    // R6 R7 timeout
    repeat (3) @(negedge clk);
    chk(rdTimeoutSts == 1'b1, "R8", "flag sticky", 32'(rdTimeoutSts), 32'd1);
    runRead(8'h30, 2'd0, 3, 1, -1, 11);    // R8 clear on timeout cycle loses
    clearSts();
    runRead(8'h34, 2'd1, 3, 1, 11, -1);    // R10 response on final edge
    chk(rdTimeoutSts == 1'b0, "R10", "no flag on tie", 32'(rdTimeoutSts), 32'd0);
    runRead(8'h40, 2'd2, 4, 3, -1, -1);    // R5 long high level counted once
    clearSts();
    idleFrames(3);                          // R5 idle edges ignored
    runRead(8'h44, 2'd0, 2, 1, 7, -1);
    runRead(8'h03, 2'd1, 3, 1, -1, -1);    // R9 crossing
    runRead(8'h02, 2'd2, 3, 1, -1, -1);    // R9 crossing
    runRead(8'h00, 2'd3, 3, 1, -1, -1);    // R9 eight bytes
    runRead(8'h02, 2'd1, 3, 1, 1, -1);     // R9 boundary exactly fits

    for (int t = 0; t < 400; t++) begin
      int p, h, r, c;
      p = 2 + int'($urandom % 3);
      h = 1 + int'($urandom % (p - 1));
      r = ($urandom % 4 == 0) ? -1 : int'($urandom % 18);
      c = ($urandom % 5 == 0) ? int'($urandom % 18) : -1;
      runRead(ADDR_W'($urandom), 2'($urandom), p, h, r, c);
      if ($urandom % 6 == 0) clearSts();
      if ($urandom % 4 == 0) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule